// File: doc/BRIEF.md
# Interrupt and DMA Request Router

This block keeps the pending-event state of a card-interface peripheral and turns it into one CPU interrupt line and two DMA request lines. Thirteen event sources each own one bit of a request register. A pulse on an event input latches its bit. A clear strobe from the register side drops the bit again. A mask register holds one bit per source, and a mask bit of 1 hides that source from the CPU interrupt.

A DMA-enable control, taken from the peripheral's command/data register, sets where the two FIFO service requests go. With the control low, the receive and transmit service bits reach the CPU interrupt like any other source, and both DMA lines stay low. With the control high, those two bits are hidden from the CPU interrupt whatever the mask holds. Each one then drives its own DMA request line directly.

A small register port lets software write the mask and read back either the mask or the request register.

Top module: `irq_dma_router`

## Requirements
- R1: During and right after reset the request and mask registers are zero, and `cpu_irq`, `rx_dma_req` and `tx_dma_req` are low.
- R2: A 1 on bit i of `evt_set` sets request bit i at the next clock edge. The bit then stays set until a clear strobe removes it.
- R3: A 1 on bit i of `evt_clr`, with `evt_set` bit i low, clears request bit i at the next clock edge.
- R4: When `evt_set` and `evt_clr` are both 1 for the same bit in the same cycle, the bit ends up set.
- R5: A write with `reg_sel`=0 loads the mask from `reg_wdata[12:0]` at the next edge and ignores the upper bits. Reading the mask returns it zero-extended to 32 bits.
- R6: A write with `reg_sel`=1, which selects the request register, changes neither the request register nor the mask.
- R7: `cpu_irq` is high exactly when some request bit is 1 and its mask bit is 0, with bits 5 and 6 subject to R8. It follows request and mask changes from the edge on which they are loaded.
- R8: While `dma_en` is 1, request bits 5 (receive service) and 6 (transmit service) never raise `cpu_irq`, whatever the mask holds.
- R9: While `dma_en` is 1, `rx_dma_req` equals request bit 5 and `tx_dma_req` equals request bit 6, independent of the mask.
- R10: While `dma_en` is 0, `rx_dma_req` and `tx_dma_req` are low.
- R11: `reg_rdata` shows the mask when `reg_sel`=0 and the request register when `reg_sel`=1, zero-extended, combinationally from the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_set | input | 13 | Per-source event pulses that set request bits |
| evt_clr | input | 13 | Per-source clear strobes from the register side |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 mask, 1 request |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| dma_en | input | 1 | Sends the FIFO service requests to the DMA lines |
| cpu_irq | output | 1 | CPU interrupt request |
| rx_dma_req | output | 1 | Receive-FIFO DMA request |
| tx_dma_req | output | 1 | Transmit-FIFO DMA request |

## Verification
Set pulses, clear strobes and mask writes are each held in one register stage. Their effect on `cpu_irq`, the DMA lines and `reg_rdata` therefore shows one edge after the cycle in which they are driven. A change of `dma_en` or `reg_sel` reaches the outputs in the same cycle, with no edge in between.

The bench drives each stimulus just after a falling edge and updates its model at the next rising edge. It compares all four outputs at the falling edge that follows, so that both the registered one-edge paths and the combinational paths are settled when sampled.

Directed steps cover set/clear collisions, ignored writes and DMA routing. A long random run then compares every cycle against the model.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned SRC_COUNT  = 13;
  localparam int unsigned BUS_WIDTH  = 32;
  localparam int unsigned RX_SVC_IDX = 5;
  localparam int unsigned TX_SVC_IDX = 6;

  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_REQ  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int unsigned N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o
);
  logic [N-1:0] req_q, req_d;
  logic         upd_en;

  // Set wins over clear: clear is applied first, set OR-ed on top.
  always_comb begin
    upd_en = |(set_i | clr_i);
    req_d  = (req_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (upd_en) req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q, mask_d;

  always_comb mask_d = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int unsigned N      = 13,
  parameter int unsigned RX_IDX = 5,
  parameter int unsigned TX_IDX = 6
) (
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] mask_i,
  input  logic         dma_en_i,
  output logic         irq_o,
  output logic         rx_o,
  output logic         tx_o
);
  logic [N-1:0] svc_bits;
  logic [N-1:0] eff_mask;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_svc
      assign svc_bits[g] = (g == RX_IDX) || (g == TX_IDX);
    end
  endgenerate

  always_comb begin
    eff_mask = mask_i | (dma_en_i ? svc_bits : '0);
    irq_o    = |(req_i & ~eff_mask);
    rx_o     = dma_en_i & req_i[RX_IDX];
    tx_o     = dma_en_i & req_i[TX_IDX];
  end
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SRC  = SRC_COUNT,
  parameter int unsigned DATA_W = BUS_WIDTH,
  parameter int unsigned RX_IDX = RX_SVC_IDX,
  parameter int unsigned TX_IDX = TX_SVC_IDX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_set,
  input  logic [N_SRC-1:0]  evt_clr,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dma_en,
  output logic              cpu_irq,
  output logic              rx_dma_req,
  output logic              tx_dma_req
);
  localparam int unsigned PAD_W = DATA_W - N_SRC;

  logic [N_SRC-1:0] req_q;
  logic [N_SRC-1:0] mask_q;
  logic             mask_wr;
  logic [PAD_W-1:0] wdata_unused;

  assign mask_wr      = reg_we && (reg_sel_e'(reg_sel) == SEL_MASK);
  assign wdata_unused = reg_wdata[DATA_W-1:N_SRC];

  irq_req_bank #(.N(N_SRC)) u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_set),
    .clr_i (evt_clr),
    .req_o (req_q)
  );

  irq_mask_reg #(.N(N_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mask_wr),
    .wdata  (reg_wdata[N_SRC-1:0]),
    .mask_o (mask_q)
  );

  irq_route #(.N(N_SRC), .RX_IDX(RX_IDX), .TX_IDX(TX_IDX)) u_route (
    .req_i    (req_q),
    .mask_i   (mask_q),
    .dma_en_i (dma_en),
    .irq_o    (cpu_irq),
    .rx_o     (rx_dma_req),
    .tx_o     (tx_dma_req)
  );

  always_comb begin
    if (reg_sel_e'(reg_sel) == SEL_REQ) reg_rdata = {{PAD_W{1'b0}}, req_q};
    else                                reg_rdata = {{PAD_W{1'b0}}, mask_q};
  end
endmodule

// File: rtl/irq_dma_router_chk.sv
module irq_dma_router_chk #(
  parameter int unsigned N_SRC  = 13,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RX_IDX = 5,
  parameter int unsigned TX_IDX = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  evt_set,
  input logic [N_SRC-1:0]  evt_clr,
  input logic              reg_we,
  input logic              reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              dma_en,
  input logic              cpu_irq,
  input logic              rx_dma_req,
  input logic              tx_dma_req,
  input logic [N_SRC-1:0]  req_q,
  input logic [N_SRC-1:0]  mask_q
);
  // R2: every set pulse lands in the request register
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we || !reg_we |=> ((req_q & $past(evt_set)) == $past(evt_set)));

  // R3: a clear without a colliding set empties the bit
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt_clr & ~evt_set) |=> ((req_q & $past(evt_clr & ~evt_set)) == '0));

  // R2: untouched bits hold
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we || !reg_we |=> (((req_q ^ $past(req_q)) & ~$past(evt_set | evt_clr)) == '0));

  // R5: mask write keeps low bits
  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel) |=> (mask_q == $past(reg_wdata[N_SRC-1:0])));

  // R6: request register write is ignored
  p_req_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel && evt_set == '0 && evt_clr == '0) |=> $stable(req_q) && $stable(mask_q));

  // R8: service bits alone never reach the CPU with DMA on
  p_dma_hides_svc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && (req_q & ~mask_q & ~(N_SRC'(1) << RX_IDX) & ~(N_SRC'(1) << TX_IDX)) == '0) |-> !cpu_irq);

  // R9: DMA lines follow service bits
  p_dma_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en |-> (rx_dma_req == req_q[RX_IDX]) && (tx_dma_req == req_q[TX_IDX]));

  // R10: DMA lines quiet with DMA off
  p_dma_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !rx_dma_req && !tx_dma_req);

  // R7: no pending unmasked source, no interrupt
  p_irq_needs_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & ~mask_q) == '0) |-> !cpu_irq);
endmodule

bind irq_dma_router irq_dma_router_chk #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .RX_IDX(RX_IDX), .TX_IDX(TX_IDX)
) u_chk (.*);

// File: tb/irq_dma_router_bench.sv
module irq_dma_router_bench;
  localparam int N = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] evt_set, evt_clr;
  logic        reg_we, reg_sel, dma_en;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cpu_irq, rx_dma_req, tx_dma_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // behavioural model state
  bit [12:0] m_req, m_mask;

  always #2 clk = ~clk;

  irq_dma_router u_irq_dma_router (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_clr(evt_clr),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dma_en(dma_en), .cpu_irq(cpu_irq),
    .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    bit exp_irq;
    exp_irq = 0;
    for (int i = 0; i < N; i++)
      if (m_req[i] && !m_mask[i] && !(dma_en && (i == 5 || i == 6))) exp_irq = 1;
    check(tag, "cpu_irq", {31'b0, cpu_irq}, {31'b0, exp_irq});
    check(tag, "rx_dma_req", {31'b0, rx_dma_req}, {31'b0, dma_en & m_req[5]});
    check(tag, "tx_dma_req", {31'b0, tx_dma_req}, {31'b0, dma_en & m_req[6]});
    check(tag, "reg_rdata", reg_rdata, {19'b0, reg_sel ? m_req : m_mask});
  endtask

  // called just after a falling edge
  task automatic step(input logic [12:0] s, input logic [12:0] c, input logic we,
                      input logic sel, input logic [31:0] wd, input logic de,
                      input string tag);
    evt_set = s; evt_clr = c; reg_we = we; reg_sel = sel; reg_wdata = wd; dma_en = de;
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (s[i])      m_req[i] = 1;
      else if (c[i]) m_req[i] = 0;
    end
    if (we && !sel) m_mask = wd[12:0];
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; evt_set = '0; evt_clr = '0; reg_we = 0; reg_sel = 0;
    reg_wdata = '0; dma_en = 0; m_req = '0; m_mask = '0;
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    compare_all("R1 after reset");
    reg_sel = 1; #1 compare_all("R1 request readback");

    step(13'h0001, '0, 0, 1, '0, 0, "R2 set bit0");
    step('0, '0, 0, 1, '0, 0, "R2 hold bit0");
    step('0, '0, 1, 0, 32'hABCD_0001, 0, "R5 mask upper bits dropped");
    step('0, '0, 0, 0, '0, 0, "R11 mask readback");
    step('0, 13'h0001, 0, 1, '0, 0, "R3 clear bit0");
    step(13'h0004, 13'h0004, 0, 1, '0, 0, "R4 set beats clear");
    step('0, '0, 1, 1, 32'h0000_0000, 0, "R6 request write ignored");
    step('0, '0, 0, 0, '0, 0, "R6 mask unchanged");
    step('0, 13'h0004, 1, 0, '0, 0, "R3 clear bit2 and unmask");
    step(13'h0020, '0, 0, 1, '0, 1, "R8 rx service hidden from cpu");
    step(13'h0040, '0, 0, 1, '0, 1, "R9 tx dma request");
    step('0, '0, 0, 1, '0, 0, "R10 dma off lines low");
    step('0, '0, 1, 0, 32'h0000_0060, 1, "R9 mask ignored on dma lines");
    step(13'h0100, '0, 0, 1, '0, 1, "R7 other source still interrupts");
    step('0, 13'h1FFF, 1, 0, '0, 0, "R3 clear all");

    for (int k = 0; k < 3000; k++) begin
      logic [12:0] rs, rc;
      rs = 13'($urandom) & 13'($urandom) & 13'($urandom);
      rc = 13'($urandom) & 13'($urandom);
      step(rs, rc, ($urandom % 4) == 0, 1'($urandom), $urandom, 1'($urandom),
           "R7 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule